// File: doc/BRIEF.md
# Locked-Update PWM Channel

This block is one pulse-width modulated output with a small register slave. The slave has a single-cycle write strobe (select plus enable plus write) and a combinational read mux. Software programs a period and a duty count, and a control word. The control word picks the polarity, the idle level and the run mode. The output is left-aligned: every period starts in the active phase and drops to the opposite level once the counter reaches the duty count.

Period, duty and polarity are always written into a staging set first. A separate active set drives the waveform. The staging set moves into the active set only at the end of a period, so the waveform never carries half of an old setting and half of a new one. A lock bit in the control word stops that transfer. Software sets the lock, rewrites period and duty at leisure, and then clears the lock in the same write that carries the new polarity. All three values then take effect together when the next period begins.

Top module: `pwm_lock_chan`

## Requirements
- R1: After reset the counter, period, duty and control registers all read 0 and the output is low.
- R2: Registers sit at byte offsets 0x0 (counter), 0x4 (period), 0x8 (duty) and 0xC (control, bits 8:0, upper bits read 0). Reading the period or duty returns the last value written (the staged value), even before it takes effect. Any other address reads 0.
- R3: A write to the counter offset 0x0 has no effect on any register or on the output.
- R4: The channel runs only when control bit 0 (enable) is 1, bits 2:1 equal 2'b01 (continuous) and bit 8 (low power) is 0. Otherwise the counter reads 0 and the output sits at the idle level given by control bit 4.
- R5: While running with an active period N of 2 or more, the counter steps through 0, 1, ... N-1 and returns to 0, one step per clock. With N of 0 or 1 it stays at 0.
- R6: While running, the output is at the active level for counts below the active duty and at the opposite level otherwise. The active level is high when control bit 3 is 1 and low when it is 0. A duty of 0 never shows the active level, and a duty at or above the period shows it for the whole period.
- R7: With the lock (control bit 6) clear, written period, duty and polarity bits reach the waveform at the clock edge that returns the counter to 0. When the channel is not running they reach it on the next clock edge.
- R8: While control bit 6 is 1, writes to period, duty and the polarity bits do not change the waveform.
- R9: A control write that clears bit 6 makes the staged period, duty and polarity take effect together at the start of the next period. The period in progress finishes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid while selected for a read |
| pwm_out | output | 1 | Modulated output |

## Verification
A wrong active register shows on pwm_out no later than the first period after a commit. It shows as a high or low run one or more clocks too long, or as the wrong level. A counter fault shows the same cycle through the live count read, which the bench samples every idle cycle. A commit taken at the wrong time, or let through under the lock, shows inside one period as a period that mixes old and new lengths or levels. The bench compares every cycle against its own arithmetic model, so such a slip shows at the clock where it happens.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;

  // control word bit positions
  localparam int CTRL_W       = 9;
  localparam int CB_EN        = 0;
  localparam int CB_MODE_LO   = 1;
  localparam int CB_MODE_HI   = 2;
  localparam int CB_DUTY_POS  = 3;
  localparam int CB_INACT_POS = 4;
  localparam int CB_LOCK      = 6;
  localparam int CB_LOWPWR    = 8;

  localparam logic [1:0] MODE_CONT = 2'b01;

  // byte offsets of the register slots
  localparam logic [7:0] OFS_CNT    = 8'h00;
  localparam logic [7:0] OFS_PERIOD = 8'h04;
  localparam logic [7:0] OFS_DUTY   = 8'h08;
  localparam logic [7:0] OFS_CTRL   = 8'h0C;

  typedef struct packed {
    logic duty_pos;
    logic inact_pos;
  } pol_t;

endpackage

// File: rtl/pwm_lock_regs.sv
module pwm_lock_regs
  import pwm_lock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [DATA_W-1:0] prdata,
  output logic [CNT_W-1:0]  stg_period,
  output logic [CNT_W-1:0]  stg_duty,
  output pol_t              stg_pol,
  output logic              lock,
  output logic              run
);

  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(OFS_PERIOD);
  localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(OFS_DUTY);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic              wr_en;
  logic              per_we, duty_we, ctrl_we;
  logic [CNT_W-1:0]  per_q, per_d;
  logic [CNT_W-1:0]  duty_q, duty_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  // write decode and next-state values
  always_comb begin
    wr_en   = psel && penable && pwrite;
    per_we  = wr_en && (paddr == A_PER);
    duty_we = wr_en && (paddr == A_DUTY);
    ctrl_we = wr_en && (paddr == A_CTRL);
    per_d   = pwdata[CNT_W-1:0];
    duty_d  = pwdata[CNT_W-1:0];
    ctrl_d  = pwdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      duty_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (per_we)  per_q  <= per_d;
      if (duty_we) duty_q <= duty_d;
      if (ctrl_we) ctrl_q <= ctrl_d;
    end
  end

  // read mux
  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (paddr)
        A_CNT:   prdata[CNT_W-1:0]  = cnt_val;
        A_PER:   prdata[CNT_W-1:0]  = per_q;
        A_DUTY:  prdata[CNT_W-1:0]  = duty_q;
        A_CTRL:  prdata[CTRL_W-1:0] = ctrl_q;
        default: prdata = '0;
      endcase
    end
  end

  // decoded fields
  always_comb begin
    stg_period         = per_q;
    stg_duty           = duty_q;
    stg_pol.duty_pos   = ctrl_q[CB_DUTY_POS];
    stg_pol.inact_pos  = ctrl_q[CB_INACT_POS];
    lock               = ctrl_q[CB_LOCK];
    run                = ctrl_q[CB_EN] && !ctrl_q[CB_LOWPWR] &&
                         (ctrl_q[CB_MODE_HI:CB_MODE_LO] == MODE_CONT);
  end

  // R3: a write aimed at the counter slot leaves every register alone
  a_r3_cnt_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && paddr == A_CNT) |=> ($stable(per_q) && $stable(duty_q) && $stable(ctrl_q)));

  // R2: staged registers move only on a bus write
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(per_q) && $stable(duty_q) && $stable(ctrl_q)));

endmodule

// File: rtl/pwm_lock_cnt.sv
module pwm_lock_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] act_period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   step_ext;
  logic             cnt_ce;

  always_comb begin
    step_ext = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    wrap     = step_ext >= {1'b0, act_period};
    cnt_ce   = 1'b1;
    if (!run || wrap) cnt_d = '0;
    else              cnt_d = step_ext[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R4: a stopped channel holds the counter at zero
  a_r4_idle_counter_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // R5: the count never reaches the active period
  a_r5_cnt_below_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_period > 1) |-> (cnt_q < act_period));

endmodule

// File: rtl/pwm_lock_commit.sv
module pwm_lock_commit
  import pwm_lock_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             run,
  input  logic             wrap,
  input  logic [CNT_W-1:0] stg_period,
  input  logic [CNT_W-1:0] stg_duty,
  input  pol_t             stg_pol,
  output logic [CNT_W-1:0] act_period,
  output logic [CNT_W-1:0] act_duty,
  output pol_t             act_pol
);

  logic             commit;
  logic [CNT_W-1:0] per_q, duty_q;
  pol_t             pol_q;

  always_comb begin
    commit = !lock && (!run || wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      duty_q <= '0;
      pol_q  <= '0;
    end else if (commit) begin
      per_q  <= stg_period;
      duty_q <= stg_duty;
      pol_q  <= stg_pol;
    end
  end

  assign act_period = per_q;
  assign act_duty   = duty_q;
  assign act_pol    = pol_q;

  // R8: nothing reaches the active set while the lock is held
  a_r8_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(per_q) && $stable(duty_q) && $stable(pol_q)));

endmodule

// File: rtl/pwm_lock_chan.sv
module pwm_lock_chan
  import pwm_lock_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pwm_out
);

  logic             rst_meta_q, rst_sync_n;
  logic [CNT_W-1:0] cnt, stg_period, stg_duty, act_period, act_duty;
  pol_t             stg_pol, act_pol;
  logic             lock, run, wrap, in_duty;

  // reset: asserted at once, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pwm_lock_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .cnt_val    (cnt),
    .prdata     (prdata),
    .stg_period (stg_period),
    .stg_duty   (stg_duty),
    .stg_pol    (stg_pol),
    .lock       (lock),
    .run        (run)
  );

  pwm_lock_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (run),
    .act_period (act_period),
    .cnt        (cnt),
    .wrap       (wrap)
  );

  pwm_lock_commit #(.CNT_W(CNT_W)) u_commit (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lock       (lock),
    .run        (run),
    .wrap       (wrap),
    .stg_period (stg_period),
    .stg_duty   (stg_duty),
    .stg_pol    (stg_pol),
    .act_period (act_period),
    .act_duty   (act_duty),
    .act_pol    (act_pol)
  );

  // left-aligned waveform from the active set
  always_comb begin
    in_duty = cnt < act_duty;
    if (!run)         pwm_out = act_pol.inact_pos;
    else if (in_duty) pwm_out = act_pol.duty_pos;
    else              pwm_out = !act_pol.duty_pos;
  end

  // R6: zero duty never shows the active level
  a_r6_zero_duty_inactive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && act_duty == '0) |-> (pwm_out == !act_pol.duty_pos));

  // R4: a stopped channel rests at the idle level
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run |-> (pwm_out == act_pol.inact_pos));

  // R9: a new duty shows up only as a running period begins
  a_r9_commit_at_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && !$stable(act_duty)) |-> (cnt == '0));

  // R9: a new period value shows up only as a running period begins
  a_r9_period_at_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && !$stable(act_period)) |-> (cnt == '0));

endmodule

// File: tb/pwm_lock_chan_bench.sv
module pwm_lock_chan_bench;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              psel, penable, pwrite;
  logic [ADDR_W-1:0] paddr;
  logic [DATA_W-1:0] pwdata;
  logic [DATA_W-1:0] prdata;
  logic              pwm_out;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done     = 1'b0;

  // reference state, built from the requirements
  logic [31:0] m_cnt, m_sper, m_sduty, m_aper, m_aduty;
  logic [8:0]  m_ctrl;
  logic        m_apol, m_ainact;

  always #(CLK_P/2) clk = ~clk;

  pwm_lock_chan #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(32)) u_pwm_lock_chan (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pwm_out (pwm_out)
  );

  function automatic bit m_run();
    return m_ctrl[0] && !m_ctrl[8] && (m_ctrl[2:1] == 2'b01);
  endfunction

  function automatic logic m_out();
    if (!m_run())          return m_ainact;
    if (m_cnt < m_aduty)   return m_apol;
    return !m_apol;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'h0:    return m_cnt;
      4'h4:    return m_sper;
      4'h8:    return m_sduty;
      4'hC:    return {23'd0, m_ctrl};
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_sper = 0; m_sduty = 0; m_aper = 0; m_aduty = 0;
    m_ctrl = 0; m_apol = 0; m_ainact = 0;
  endtask

  // one clock edge of the model
  task automatic m_edge(input bit w, input logic [3:0] a, input logic [31:0] d);
    bit run_now, wrap_now, commit;
    run_now  = m_run();
    wrap_now = ({1'b0, m_cnt} + 33'd1) >= {1'b0, m_aper};
    commit   = !m_ctrl[6] && (!run_now || wrap_now);
    if (commit) begin
      m_aper   = m_sper;
      m_aduty  = m_sduty;
      m_apol   = m_ctrl[3];
      m_ainact = m_ctrl[4];
    end
    m_cnt = (!run_now || wrap_now) ? 32'd0 : m_cnt + 32'd1;
    if (w) begin
      case (a)
        4'h4:    m_sper  = d;
        4'h8:    m_sduty = d;
        4'hC:    m_ctrl  = d[8:0];
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at negedge, model the edge, sample at next negedge
  task automatic cyc(input bit sel, input bit wr, input logic [3:0] a,
                     input logic [31:0] d, input string tag);
    psel = sel; penable = sel; pwrite = wr; paddr = a; pwdata = d;
    @(posedge clk);
    m_edge(sel && wr, a, d);
    @(negedge clk);
    check(tag, {31'd0, pwm_out}, {31'd0, m_out()});
    if (sel && !wr) check((a == 4'h0) ? "R5" : "R2", prdata, m_read(a));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 4'h0, 32'd0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, tag);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'd0, tag);
  endtask

  initial begin
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    rst_n = 1'b0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values at the ports
    check("R1", {31'd0, pwm_out}, 32'd0);
    rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1"); rd(4'hC, "R1");

    // R2: map, staged readback, control masking, unmapped address
    wr(4'h4, 32'hABCD_0123, "R2");
    wr(4'h8, 32'h0000_1234, "R2");
    wr(4'hC, 32'hFFFF_FE50, "R2");
    rd(4'h4, "R2"); rd(4'h8, "R2"); rd(4'hC, "R2"); rd(4'h6, "R2");
    wr(4'hC, 32'h0, "R2");

    // R3: counter write leaves every register and the output alone
    wr(4'h0, 32'hFFFF_FFFF, "R3");
    rd(4'h0, "R3"); rd(4'h4, "R3"); rd(4'h8, "R3"); rd(4'hC, "R3");

    // R5 / R6: sweep period, duty and polarity
    begin
      int plist [6] = '{0, 1, 2, 3, 5, 8};
      foreach (plist[pi]) begin
        for (int di = 0; di < 6; di++) begin
          for (int pol = 0; pol < 2; pol++) begin
            int p, dv, polcfg, ncyc;
            p = plist[pi];
            case (di)
              0: dv = 0;
              1: dv = 1;
              2: dv = p / 2;
              3: dv = (p > 0) ? p - 1 : 0;
              4: dv = p;
              default: dv = p + 2;
            endcase
            polcfg = pol ? 32'h10 : 32'h08;
            wr(4'h4, p, "R6");
            wr(4'h8, dv, "R6");
            wr(4'hC, polcfg, "R4");
            idle(2, "R4");
            wr(4'hC, polcfg | 32'h3, "R6");
            ncyc = 2 * ((p > 1) ? p : 1) + 2;
            idle(ncyc, "R6");
            wr(4'hC, polcfg, "R4");
            idle(2, "R4");
          end
        end
      end
    end

    // R4: mode and low-power settings that must not run
    wr(4'h4, 32'd6, "R4");
    wr(4'h8, 32'd3, "R4");
    wr(4'hC, 32'h018, "R4");   // idle high
    idle(2, "R4");
    wr(4'hC, 32'h019, "R4");   // mode 00
    idle(4, "R4");
    wr(4'hC, 32'h01D, "R4");   // mode 10
    idle(4, "R4");
    wr(4'hC, 32'h01F, "R4");   // mode 11
    idle(4, "R4");
    wr(4'hC, 32'h01A, "R4");   // enable off
    idle(4, "R4");
    wr(4'hC, 32'h11B, "R4");   // low power on
    idle(4, "R4");
    wr(4'hC, 32'h01B, "R4");   // runs
    idle(8, "R4");

    // R7: unlocked mid-period rewrite lands at the wrap
    wr(4'h4, 32'd10, "R7");
    wr(4'h8, 32'd3, "R7");
    wr(4'hC, 32'h00B, "R7");
    idle(14, "R7");
    wr(4'h4, 32'd6, "R7");
    wr(4'h8, 32'd5, "R7");
    idle(3, "R7");
    wr(4'hC, 32'h013, "R7");   // polarity flip, unlocked
    idle(25, "R7");

    // R8: lock holds the waveform through rewrites
    wr(4'h4, 32'd8, "R8");
    wr(4'h8, 32'd2, "R8");
    idle(20, "R8");
    wr(4'hC, 32'h04B, "R8");
    wr(4'h4, 32'd5, "R8");
    wr(4'h8, 32'd4, "R8");
    wr(4'hC, 32'h053, "R8");   // locked, inverted staged
    idle(3, "R8");
    rd(4'h4, "R8"); rd(4'h8, "R8");
    idle(20, "R8");

    // R9: unlock mid-period, all three land together next period
    idle(3, "R9");
    wr(4'hC, 32'h013, "R9");
    idle(24, "R9");

    // R9: unlock exactly on the last count of a period
    wr(4'hC, 32'h04B, "R9");
    wr(4'h4, 32'd7, "R9");
    wr(4'h8, 32'd6, "R9");
    idle(9, "R9");
    wr(4'hC, 32'h00B, "R9");
    idle(20, "R9");

    psel = 0; penable = 0; pwrite = 0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule